// File: doc/BRIEF.md
# Mailbox request event assembler

This block sits between a bank of per-function mailbox registers and the agent that services requests from those functions. Every 32-bit mailbox write becomes an inbound event tagged with the mailbox number. The block then reads each event as a sequence number, a type code and a 16-bit payload. A function posts a request by sending four request-word events in a row. Each carries one quarter of a 64-bit request address, and their sequence numbers step by one. When all four arrive intact and the address falls on a 4 KiB boundary, the block presents the address and the mailbox number on a one-cycle request port.

A mailbox that sends a broken chain, a wrong type or an unaligned address gets no request and no answer. Assembly progress is held separately for every mailbox, so writes to different mailboxes may interleave freely.

In the other direction, the block formats status and reset notifications toward the functions. Each one is posted with a single-cycle strobe and held on a valid/ready output. The outbound sequence counter has no link to any inbound sequence.

Top module: `mbx_req_assembler`

## Requirements
- R1: A write with `wr_valid` high produces, on the next cycle, `ev_valid` high with `ev_qid` equal to the written mailbox index and `ev_value` equal to the written word.
- R2: An event word is decoded as payload in bits 15:0, type in bits 23:16 and sequence number in bits 31:24. Types 0 to 3 are request words 0 to 3, type 4 is status and type 5 is reset.
- R3: Four events on one mailbox form a request when they have types 0, 1, 2 and 3 in order and sequence numbers S, S+1, S+2 and S+3. The request address is {payload3, payload2, payload1, payload0}. `req_valid` pulses for one cycle, one cycle after the type-3 event (two cycles after its write), with `req_qid` set to the mailbox.
- R4: When the assembled address has any of bits 11:0 set, no request is issued and the mailbox returns to idle.
- R5: A word that is not the next expected request word, or whose sequence is not the previous plus one, discards the partial request with no request. If that word has type 0, assembly restarts from it.
- R6: Assembly state is kept per mailbox (default 128), so chains on different mailboxes may interleave without affecting each other.
- R7: Sequence numbers are compared modulo 256, so a chain may run through 255 to 0.
- R8: An outbound event is `ob_word` = {sequence[31:24], type[23:16], 16'h0000}, with type 4 for status and type 5 for reset. Once `ob_valid` is high, it and `ob_word` hold until `ob_ready` is seen.
- R9: The outbound sequence starts at 0 after reset, advances by one (mod 256) only on a cycle with `ob_valid` and `ob_ready` both high, and is independent of all inbound sequences.
- R10: A pending reset notification is offered before a pending status notification. Posts that arrive while an event is in flight are remembered and sent later.
- R11: During and just after reset, `ev_valid`, `req_valid` and `ob_valid` are low and no mailbox holds a partial request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Mailbox register write strobe |
| wr_idx | input | IDX_W | Index of the mailbox written |
| wr_data | input | 32 | Word written to the mailbox |
| ev_valid | output | 1 | Inbound event valid |
| ev_qid | output | IDX_W | Mailbox index of the inbound event |
| ev_value | output | 32 | Value of the inbound event |
| req_valid | output | 1 | One-cycle request strobe |
| req_qid | output | IDX_W | Mailbox that posted the request |
| req_addr | output | 64 | Page-aligned request address |
| post_status | input | 1 | Queue a status notification |
| post_reset | input | 1 | Queue a reset notification |
| ob_valid | output | 1 | Outbound event valid |
| ob_ready | input | 1 | Outbound event accepted |
| ob_word | output | 32 | Outbound event word |

## Verification
The in-line properties check four things on every cycle: a write always becomes an event on the next cycle, every request is aligned and follows a type-3 event whose payload forms its top address bits, a stalled outbound word never moves, and the outbound sequence changes only on acceptance. Other behaviour only shows up in the bench scenarios, run against a behavioural reference model. That covers whether a chain is accepted or discarded, restarts from a fresh type-0 word, per-mailbox isolation under interleaving, sequence wrap, and the ordering of reset ahead of status.

// File: rtl/mbx_req_assembler.sv
module mbx_req_assembler #(
  parameter int N_MBX = 128,
  parameter int IDX_W = (N_MBX > 1) ? $clog2(N_MBX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  output logic             ev_valid,
  output logic [IDX_W-1:0] ev_qid,
  output logic [31:0]      ev_value,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_qid,
  output logic [63:0]      req_addr,
  input  logic             post_status,
  input  logic             post_reset,
  output logic             ob_valid,
  input  logic             ob_ready,
  output logic [31:0]      ob_word
);
  localparam logic [7:0] TYP_STATUS = 8'd4;
  localparam logic [7:0] TYP_RESET  = 8'd5;

  logic [1:0]  stage  [N_MBX];
  logic [7:0]  lastsq [N_MBX];
  logic [15:0] part0  [N_MBX];
  logic [15:0] part1  [N_MBX];
  logic [15:0] part2  [N_MBX];

  wire [7:0]  e_seq  = ev_value[31:24];
  wire [7:0]  e_type = ev_value[23:16];
  wire [15:0] e_data = ev_value[15:0];
  wire [1:0]  cur_st = stage[ev_qid];
  wire [7:0]  cur_sq = lastsq[ev_qid];

  wire        chain_ok = (cur_st != 2'd0) && (e_type == {6'd0, cur_st}) &&
                         (e_seq == cur_sq + 8'd1);
  wire        last_wd  = ev_valid && chain_ok && (cur_st == 2'd3);
  wire [63:0] full     = {e_data, part2[ev_qid], part1[ev_qid], part0[ev_qid]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_qid   <= '0;
      ev_value <= '0;
    end else begin
      ev_valid <= wr_valid;
      ev_qid   <= wr_idx;
      ev_value <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_MBX; i++) stage[i] <= 2'd0;
    end else if (ev_valid) begin
      if (chain_ok)             stage[ev_qid] <= cur_st + 2'd1;
      else if (e_type == 8'd0)  stage[ev_qid] <= 2'd1;
      else                      stage[ev_qid] <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_valid) begin
      if (chain_ok) begin
        lastsq[ev_qid] <= e_seq;
        if (cur_st == 2'd1) part1[ev_qid] <= e_data;
        if (cur_st == 2'd2) part2[ev_qid] <= e_data;
      end else if (e_type == 8'd0) begin
        lastsq[ev_qid] <= e_seq;
        part0[ev_qid]  <= e_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_qid   <= '0;
      req_addr  <= '0;
    end else begin
      req_valid <= last_wd && (full[11:0] == 12'd0);
      if (last_wd) begin
        req_qid  <= ev_qid;
        req_addr <= full;
      end
    end
  end

  logic       pend_st, pend_rs, ob_isrst;
  logic [7:0] oseq;
  wire        acc   = ob_valid && ob_ready;
  wire        rs_in = pend_rs || post_reset;
  wire        st_in = pend_st || post_status;
  wire        load  = !ob_valid && (rs_in || st_in);

  assign ob_word = {oseq, ob_isrst ? TYP_RESET : TYP_STATUS, 16'h0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_valid <= 1'b0;
      ob_isrst <= 1'b0;
      pend_st  <= 1'b0;
      pend_rs  <= 1'b0;
      oseq     <= 8'd0;
    end else begin
      if (acc) begin
        oseq     <= oseq + 8'd1;
        ob_valid <= 1'b0;
      end
      if (load) begin
        ob_valid <= 1'b1;
        ob_isrst <= rs_in;
      end
      pend_rs <= rs_in && !load;
      pend_st <= st_in && !(load && !rs_in);
    end
  end

  assert_ev_follows_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ev_valid && ev_qid == $past(wr_idx) && ev_value == $past(wr_data));

  assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[11:0] == 12'd0);

  assert_req_after_word3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(ev_valid) && $past(ev_value[23:16]) == 8'd3 &&
                  $past(ev_value[15:0]) == req_addr[63:48]);

  assert_ob_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && !ob_ready |=> ob_valid && $stable(ob_word));

  assert_ob_seq_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> oseq == $past(oseq) + 8'd1);

  assert_ob_seq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> oseq == $past(oseq));
endmodule

// File: tb/mbx_req_assembler_tb.sv
module mbx_req_assembler_tb_top;
  localparam int CLK_P = 10;
  localparam int NM    = 128;
  localparam int IW    = 7;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0; logic [IW-1:0] wr_idx = '0; logic [31:0] wr_data = '0;
  logic post_status = 0, post_reset = 0, ob_ready = 0;
  logic ev_valid, req_valid, ob_valid;
  logic [IW-1:0] ev_qid, req_qid;
  logic [31:0] ev_value, ob_word;
  logic [63:0] req_addr;

  always #(CLK_P/2) clk = ~clk;

  mbx_req_assembler #(.N_MBX(NM), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .ev_valid(ev_valid), .ev_qid(ev_qid), .ev_value(ev_value),
    .req_valid(req_valid), .req_qid(req_qid), .req_addr(req_addr),
    .post_status(post_status), .post_reset(post_reset),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_word(ob_word));

  int vec = 0, mis = 0;
  bit checking = 0;
  int req_seen = 0;
  logic [63:0] last_addr;
  logic [IW-1:0] last_qid;
  logic [31:0] ob_seen [$];

  // behavioural reference model
  bit m_ev_v; int m_ev_q; logic [31:0] m_ev_val;
  bit m_req_v; int m_req_q; logic [63:0] m_req_a;
  int mst [NM]; int mls [NM]; logic [15:0] mw [NM][3];
  bit m_obv, m_obr, m_pr, m_ps; int m_seq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ev_v = 0; m_req_v = 0; m_obv = 0; m_pr = 0; m_ps = 0; m_seq = 0; m_obr = 0;
      for (int i = 0; i < NM; i++) mst[i] = 0;
    end else begin
      bit old_v, pr, ps;
      m_req_v = 0;
      if (m_ev_v) begin
        int q, t, s; logic [15:0] d; logic [63:0] a;
        q = m_ev_q; t = m_ev_val[23:16]; s = m_ev_val[31:24]; d = m_ev_val[15:0];
        if (mst[q] != 0 && t == mst[q] && s == (mls[q] + 1) % 256) begin
          mls[q] = s;
          if (mst[q] == 3) begin
            a = {d, mw[q][2], mw[q][1], mw[q][0]};
            if (a[11:0] == 0) begin m_req_v = 1; m_req_q = q; m_req_a = a; end
            mst[q] = 0;
          end else begin
            mw[q][mst[q]] = d; mst[q]++;
          end
        end else if (t == 0) begin
          mw[q][0] = d; mls[q] = s; mst[q] = 1;
        end else mst[q] = 0;
      end
      m_ev_v = wr_valid; m_ev_q = wr_idx; m_ev_val = wr_data;
      old_v = m_obv; pr = m_pr || post_reset; ps = m_ps || post_status;
      if (old_v && ob_ready) begin m_seq = (m_seq + 1) % 256; m_obv = 0; end
      if (!old_v && (pr || ps)) begin
        m_obv = 1; m_obr = pr;
        if (pr) pr = 0; else ps = 0;
      end
      m_pr = pr; m_ps = ps;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk("R1", "ev_valid", ev_valid, m_ev_v);
    if (m_ev_v) begin
      chk("R1", "ev_qid", ev_qid, m_ev_q);
      chk("R1", "ev_value", ev_value, m_ev_val);
    end
    chk("R3", "req_valid", req_valid, m_req_v);
    if (m_req_v) begin
      chk("R3", "req_qid", req_qid, m_req_q);
      chk("R3", "req_addr", req_addr, m_req_a);
    end
    chk("R8", "ob_valid", ob_valid, m_obv);
    if (m_obv) chk("R8", "ob_word", ob_word, {m_seq[7:0], m_obr ? 8'd5 : 8'd4, 16'h0});
    if (req_valid) begin req_seen++; last_addr = req_addr; last_qid = req_qid; end
    if (ob_valid && ob_ready) ob_seen.push_back(ob_word);
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int idx, int typ, int sq, logic [15:0] d);
    wr_valid = 1; wr_idx = idx[IW-1:0]; wr_data = {sq[7:0], typ[7:0], d};
    step();
    wr_valid = 0;
  endtask

  task automatic req4(int idx, int sq, logic [63:0] a);
    for (int k = 0; k < 4; k++) wr(idx, k, (sq + k) % 256, a[16*k +: 16]);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    mis++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int base;
    step(3);
    // R11: reset state visible at the ports
    chk("R11", "ev_valid@rst", ev_valid, 0);
    chk("R11", "req_valid@rst", req_valid, 0);
    chk("R11", "ob_valid@rst", ob_valid, 0);
    rst_n = 1; checking = 1;
    step(2);

    // R2 R3: clean request on mailbox 3
    base = req_seen;
    req4(3, 10, 64'h0123_4567_89ab_c000);
    step(2);
    chk("R3", "req count", req_seen - base, 1);
    chk("R3", "addr literal", last_addr, 64'h0123_4567_89ab_c000);
    chk("R3", "qid literal", last_qid, 3);

    // R4: unaligned address yields nothing
    base = req_seen;
    req4(5, 20, 64'h0000_0000_0000_1004);
    step(2);
    chk("R4", "unaligned req count", req_seen - base, 0);

    // R5: broken sequence drops, a type-0 word restarts
    base = req_seen;
    wr(7, 0, 40, 16'h1000); wr(7, 1, 42, 16'h0002); wr(7, 2, 43, 16'h0003); wr(7, 3, 44, 16'h0004);
    step(2);
    chk("R5", "broken seq count", req_seen - base, 0);
    wr(7, 0, 50, 16'hdead); wr(7, 1, 51, 16'h0001);
    req4(7, 60, 64'h0004_0003_0002_0000);
    step(2);
    chk("R5", "restart count", req_seen - base, 1);
    chk("R5", "restart addr", last_addr, 64'h0004_0003_0002_0000);
    base = req_seen;
    wr(8, 0, 1, 16'h0000); wr(8, 2, 2, 16'h0000); wr(8, 3, 3, 16'h0000);
    step(2);
    chk("R5", "wrong type count", req_seen - base, 0);

    // R6: interleaved chains on mailboxes 0 and 127
    base = req_seen;
    for (int k = 0; k < 4; k++) begin
      wr(0, k, 100 + k, 16'h1000 * k[15:0]);
      wr(127, k, 200 + k, 16'h2000 + k[15:0]);
    end
    step(2);
    chk("R6", "interleave count", req_seen - base, 2);
    chk("R6", "last qid", last_qid, 127);

    // R7: sequence wrap 254..1
    base = req_seen;
    req4(9, 254, 64'hfeed_beef_0000_5000);
    step(2);
    chk("R7", "wrap count", req_seen - base, 1);

    // R8 R10: stalled status held, reset preferred over status
    ob_ready = 0;
    post_status = 1; step(); post_status = 0;
    step(3);
    chk("R8", "held word", ob_word, 32'h0004_0000);
    post_reset = 1; post_status = 1; step(); post_reset = 0; post_status = 0;
    ob_ready = 1; step(8);
    chk("R9", "accepted count", ob_seen.size(), 3);
    if (ob_seen.size() == 3) begin
      chk("R10", "first", ob_seen[0], 32'h0004_0000);
      chk("R10", "second", ob_seen[1], 32'h0105_0000);
      chk("R10", "third", ob_seen[2], 32'h0204_0000);
    end

    // R9: outbound sequence wraps after 256 accepts
    post_status = 1; step(560); post_status = 0; step(4);
    chk("R9", "seq wrap sample", ob_seen[256], 32'h0004_0000);

    // mixed random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      ob_ready = $urandom_range(0, 1);
      post_status = ($urandom_range(0, 15) == 0);
      post_reset  = ($urandom_range(0, 31) == 0);
      if (r < 6) req4($urandom_range(0, 3), $urandom_range(0, 255),
                      {$urandom, $urandom} & ~64'(($urandom_range(0, 3) == 0) ? 0 : 64'hfff));
      else if (r < 9) wr($urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 255), 16'($urandom));
      else step();
    end
    post_status = 0; post_reset = 0; ob_ready = 1;
    step(10);
    finish_run();
  end
endmodule